// File: doc/BRIEF.md
# Pipelined Carry-Less Polynomial Multiplier

This block multiplies two binary polynomials of degree below W. Each operand bit is the coefficient of one power of x. Partial products are summed with XOR instead of addition, so no carry moves between bit positions. The exact product has 2W bits. A select input chooses which W-bit half is returned: the lower half or the upper half.

A crypto execution unit issues an operation by raising `in_valid` for one cycle. The operation carries its two operands, the half select and a destination tag. The tag and the valid flag travel through the pipeline with the data. The result appears at the output three clock edges after the operation is sampled. A new operation may be issued on every cycle.

The operand width W may be 32, 64 or 128. The number of partial-product groups formed in the middle stage is also a parameter. Reduction modulo a field polynomial is left to other logic.

Top module: `clmul_pipe`

## Requirements
- R1: With `in_hi` = 0, `out_data` equals bits W-1..0 of the carry-less product of `in_a` and `in_b`.
- R2: With `in_hi` = 1, `out_data` equals bits 2W-1..W of the same carry-less product.
- R3: An operation sampled with `in_valid` = 1 at a rising edge makes `out_valid` high exactly three rising edges later. A cycle with no operation sampled gives `out_valid` = 0 three edges later.
- R4: Operations issued on consecutive cycles each produce their own correct result on consecutive cycles, with no bubble between them.
- R5: `out_tag` equals the `in_tag` sampled with the operation whose result is on `out_data`.
- R6: A high-half result always has bit W-1 of `out_data` clear, because the product has degree at most 2W-2.
- R7: The synchronous reset `rst` clears every pipeline valid bit. Operations in flight when reset is applied never appear, and `out_valid` is 0 after any edge sampled with `rst` = 1.
- R8: The parameter W accepts only 32, 64 or 128. Elaboration stops for any other value, and also when the group count does not divide W. At W = 128 the results meet R1 and R2.
- R9: A zero operand gives a zero result for either half. A low-half operation with `in_b` = 1 returns `in_a` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present this cycle |
| in_hi | input | 1 | Half select: 0 = lower W bits, 1 = upper W bits |
| in_tag | input | TAG_W | Destination tag carried with the operation |
| in_a | input | W | Multiplicand polynomial |
| in_b | input | W | Multiplier polynomial |
| out_valid | output | 1 | Result present this cycle |
| out_tag | output | TAG_W | Tag of the returned result |
| out_data | output | W | Selected half of the product |

## Verification
Zero operands check that no partial product leaks into the result. A multiplier of 1 checks that the operand passes through unshifted. All-ones operands put the most overlapping terms into each bit, so they catch AND-instead-of-XOR and carry errors. Single-bit operands place one term at a known position, which shows whether the shifts are right and whether a term lands in the correct half. Random operands are issued back to back, with random gaps and both half selects, and the run includes a reset while operations are in flight. This separates latency, tag-alignment and valid-clearing faults from arithmetic faults, both at W = 32 and at W = 128.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
   typedef enum logic {
      HALF_LO = 1'b0,
      HALF_HI = 1'b1
   } half_sel_e;

   localparam int unsigned PIPE_DEPTH = 3;
endpackage

// File: rtl/clmul_group.sv
// Sums one contiguous slice of partial products: the terms for bits
// LO..LO+CNT-1 of the multiplier, each a shifted copy of the multiplicand.
module clmul_group #(
   parameter int unsigned W   = 32,
   parameter int unsigned LO  = 0,
   parameter int unsigned CNT = 8
) (
   input  logic [W-1:0]   a,
   input  logic [W-1:0]   b,
   output logic [2*W-1:0] acc
);
   localparam int unsigned PW = 2 * W;

   always_comb begin
      acc = '0;
      for (int unsigned j = 0; j < CNT; j++) begin
         if (b[LO+j]) begin
            acc = acc ^ ({{W{1'b0}}, a} << (LO + j));
         end
      end
   end

   logic unused_pw;
   assign unused_pw = (PW == 0);
endmodule

// File: rtl/clmul_fold.sv
// Combines the group sums into the full product and picks the requested half.
module clmul_fold #(
   parameter int unsigned W = 32,
   parameter int unsigned G = 4
) (
   input  logic [G*2*W-1:0] parts,
   input  logic             hi,
   output logic [W-1:0]     y
);
   localparam int unsigned PW = 2 * W;

   logic [PW-1:0] full;

   always_comb begin
      full = '0;
      for (int unsigned g = 0; g < G; g++) begin
         full = full ^ parts[g*PW +: PW];
      end
   end

   assign y = hi ? full[PW-1:W] : full[W-1:0];
endmodule

// File: rtl/clmul_pipe.sv
module clmul_pipe
   import clmul_pkg::*;
#(
   parameter int unsigned W       = 32,
   parameter int unsigned TAG_W   = 5,
   parameter int unsigned NGROUPS = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic             in_hi,
   input  logic [TAG_W-1:0] in_tag,
   input  logic [W-1:0]     in_a,
   input  logic [W-1:0]     in_b,
   output logic             out_valid,
   output logic [TAG_W-1:0] out_tag,
   output logic [W-1:0]     out_data
);
   localparam int unsigned PW   = 2 * W;
   localparam int unsigned GLEN = W / NGROUPS;

   // Elaboration-time parameter checks (R8)
   if (W != 32 && W != 64 && W != 128) begin : g_bad_width
      $error("clmul_pipe: W must be 32, 64 or 128");
   end
   if (NGROUPS == 0 || (W % NGROUPS) != 0) begin : g_bad_groups
      $error("clmul_pipe: NGROUPS must divide W");
   end
   if (TAG_W == 0) begin : g_bad_tag
      $error("clmul_pipe: TAG_W must be nonzero");
   end

   // Stage 1: operand capture
   logic             s1_v;
   half_sel_e        s1_half;
   logic [TAG_W-1:0] s1_tag;
   logic [W-1:0]     s1_a, s1_b;

   always_ff @(posedge clk) begin
      if (rst) s1_v <= 1'b0;
      else     s1_v <= in_valid;
      s1_half <= half_sel_e'(in_hi);
      s1_tag  <= in_tag;
      s1_a    <= in_a;
      s1_b    <= in_b;
   end

   // Stage 2: grouped partial-product sums
   logic [NGROUPS*PW-1:0] grp_sum;

   for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
      clmul_group #(
         .W   (W),
         .LO  (g * GLEN),
         .CNT (GLEN)
      ) u_grp (
         .a   (s1_a),
         .b   (s1_b),
         .acc (grp_sum[g*PW +: PW])
      );
   end

   logic                  s2_v;
   half_sel_e             s2_half;
   logic [TAG_W-1:0]      s2_tag;
   logic [NGROUPS*PW-1:0] s2_parts;

   always_ff @(posedge clk) begin
      if (rst) s2_v <= 1'b0;
      else     s2_v <= s1_v;
      s2_half  <= s1_half;
      s2_tag   <= s1_tag;
      s2_parts <= grp_sum;
   end

   // Stage 3: fold and half select
   logic [W-1:0] half_res;

   clmul_fold #(
      .W (W),
      .G (NGROUPS)
   ) u_fold (
      .parts (s2_parts),
      .hi    (s2_half == HALF_HI),
      .y     (half_res)
   );

   always_ff @(posedge clk) begin
      if (rst) out_valid <= 1'b0;
      else     out_valid <= s2_v;
      out_tag  <= s2_tag;
      out_data <= half_res;
   end
endmodule

// File: rtl/clmul_pipe_chk.sv
module clmul_pipe_chk #(
   parameter int unsigned W     = 32,
   parameter int unsigned TAG_W = 5
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             in_hi,
   input logic [TAG_W-1:0] in_tag,
   input logic [W-1:0]     in_a,
   input logic [W-1:0]     in_b,
   input logic             out_valid,
   input logic [TAG_W-1:0] out_tag,
   input logic [W-1:0]     out_data
);
   // edges since reset, saturating at the pipeline depth
   logic [1:0] since_rst;
   always_ff @(posedge clk) begin
      if (rst)                   since_rst <= 2'd0;
      else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
   end

   assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

   assert_tag_follows_R5: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd3 && out_valid) |-> (out_tag == $past(in_tag, 3)));

   assert_hi_top_clear_R6: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd3 && out_valid && $past(in_hi, 3)) |-> !out_data[W-1]);

   assert_zero_operand_R9: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd3 && $past(in_valid && (in_a == '0 || in_b == '0), 3))
         |-> (out_data == '0));

   assert_unit_multiplier_R9: assert property (@(posedge clk) disable iff (rst)
      (since_rst == 2'd3 && $past(in_valid && !in_hi && in_b == W'(1), 3))
         |-> (out_data == $past(in_a, 3)));

   assert_reset_clears_R7: assert property (@(posedge clk)
      rst |=> !out_valid);
endmodule

bind clmul_pipe clmul_pipe_chk #(
   .W     (W),
   .TAG_W (TAG_W)
) u_clmul_pipe_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_hi     (in_hi),
   .in_tag    (in_tag),
   .in_a      (in_a),
   .in_b      (in_b),
   .out_valid (out_valid),
   .out_tag   (out_tag),
   .out_data  (out_data)
);

// File: tb/clmul_pipe_bench.sv
module clmul_pipe_bench;
   localparam int TW = 5;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst;
   logic          in_valid, in_hi;
   logic [TW-1:0] in_tag;
   logic [127:0]  a_w, b_w;

   logic          nv, wv;
   logic [TW-1:0] nt, wt;
   logic [31:0]   nd;
   logic [127:0]  wd;

   clmul_pipe #(.W(32), .TAG_W(TW), .NGROUPS(4)) u_clmul_pipe (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_hi(in_hi), .in_tag(in_tag),
      .in_a(a_w[31:0]), .in_b(b_w[31:0]),
      .out_valid(nv), .out_tag(nt), .out_data(nd));

   clmul_pipe #(.W(128), .TAG_W(TW), .NGROUPS(8)) u_clmul_pipe_wide (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_hi(in_hi), .in_tag(in_tag),
      .in_a(a_w), .in_b(b_w),
      .out_valid(wv), .out_tag(wt), .out_data(wd));

   int checks = 0;
   int errors = 0;
   int streak = 0;

   // bit-serial shift-and-XOR reference
   function automatic logic [255:0] ref_mul(input logic [127:0] a, input logic [127:0] b,
                                            input int w);
      logic [255:0] p = '0;
      for (int i = 0; i < w; i++) begin
         if (b[i]) p = p ^ ({128'd0, a} << i);
      end
      return p;
   endfunction

   function automatic logic [127:0] ref_half(input logic [127:0] a, input logic [127:0] b,
                                             input int w, input logic hi);
      logic [255:0] p;
      logic [127:0] m;
      p = ref_mul(a, b, w);
      m = (w == 128) ? '1 : ((128'd1 << w) - 128'd1);
      return hi ? (128'(p >> w) & m) : (p[127:0] & m);
   endfunction

   // cycle-by-cycle model: three stages per width
   logic          mv [3];
   logic [TW-1:0] mt [3];
   logic [31:0]   mn [3];
   logic [127:0]  mw [3];
   logic          mhi [3];
   logic          mzero [3];

   always @(posedge clk) begin
      for (int k = 2; k > 0; k--) begin
         mv[k] <= rst ? 1'b0 : mv[k-1];
         mt[k] <= mt[k-1]; mn[k] <= mn[k-1]; mw[k] <= mw[k-1];
         mhi[k] <= mhi[k-1]; mzero[k] <= mzero[k-1];
      end
      mv[0]    <= rst ? 1'b0 : in_valid;
      mt[0]    <= in_tag;
      mn[0]    <= 32'(ref_half({96'd0, a_w[31:0]}, {96'd0, b_w[31:0]}, 32, in_hi));
      mw[0]    <= ref_half(a_w, b_w, 128, in_hi);
      mhi[0]   <= in_hi;
      mzero[0] <= (a_w[31:0] == 0) || (b_w[31:0] == 0);
   end

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      if (!rst) begin
         chk(nv == mv[2], "R3 valid(W32)", 128'(nv), 128'(mv[2]));
         chk(wv == mv[2], "R3 valid(W128)", 128'(wv), 128'(mv[2]));
         if (mv[2]) begin
            chk(nt == mt[2], "R5 tag", 128'(nt), 128'(mt[2]));
            chk(wt == mt[2], "R5 tag wide", 128'(wt), 128'(mt[2]));
            chk(nd == mn[2], mzero[2] ? "R9 zero operand" : (mhi[2] ? "R2 high half" : "R1 low half"),
                128'(nd), 128'(mn[2]));
            chk(wd == mw[2], "R8 W=128 result", wd, mw[2]);
            if (mhi[2]) chk(nd[31] == 1'b0 && wd[127] == 1'b0, "R6 top bit clear",
                            {wd[127], 126'd0, nd[31]}, 128'd0);
            streak++;
            if (streak >= 2) chk(nv && nd == mn[2], "R4 back-to-back", 128'(nd), 128'(mn[2]));
         end else begin
            streak = 0;
         end
      end
   end

   task automatic issue(input logic [127:0] a, input logic [127:0] b, input logic hi,
                        input logic [TW-1:0] tag);
      in_valid = 1'b1; in_hi = hi; in_tag = tag; a_w = a; b_w = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      in_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst = 1'b1; in_valid = 1'b0; in_hi = 1'b0; in_tag = '0; a_w = '0; b_w = '0;
      for (int k = 0; k < 3; k++) mv[k] = 1'b0;
      repeat (4) @(negedge clk);
      chk(!nv && !wv, "R7 reset state", 128'({nv, wv}), 128'd0);
      rst = 1'b0;
      @(negedge clk);

      // directed corners
      issue('0, '1, 1'b0, 5'd1);
      issue('1, '0, 1'b1, 5'd2);
      issue('1, '1, 1'b0, 5'd3);
      issue('1, '1, 1'b1, 5'd4);
      issue({4{32'h1234_5678}}, 128'd1, 1'b0, 5'd5);   // R9 unit multiplier
      issue(128'd1 << 31, 128'd1 << 31, 1'b1, 5'd6);
      issue(128'd1 << 127, 128'd1 << 127, 1'b1, 5'd7);
      issue(128'd1 << 31, 128'd1, 1'b0, 5'd8);
      issue(128'h8000_0000, 128'h2, 1'b1, 5'd9);        // crosses into upper half
      issue(128'h3, 128'h3, 1'b0, 5'd10);              // 101b, no carry
      idle(4);
      for (int s = 0; s < 32; s++) begin
         issue(128'd1 << s, 128'd1 << (31 - s), s[0], 5'(s));
      end
      idle(4);

      // random, mostly back to back
      for (int i = 0; i < 3000; i++) begin
         in_valid = ($urandom_range(0, 7) != 0);
         in_hi    = $urandom_range(0, 1) != 0;
         in_tag   = TW'($urandom);
         a_w      = {$urandom, $urandom, $urandom, $urandom};
         b_w      = {$urandom, $urandom, $urandom, $urandom};
         @(negedge clk);
      end

      // reset with operations in flight (R7)
      issue({4{$urandom}}, {4{$urandom}}, 1'b0, 5'd11);
      issue({4{$urandom}}, {4{$urandom}}, 1'b1, 5'd12);
      rst = 1'b1;
      @(negedge clk);
      chk(!nv && !wv, "R7 reset mid-flight", 128'({nv, wv}), 128'd0);
      rst = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(!nv && !wv, "R7 flushed after reset", 128'({nv, wv}), 128'd0);
      end

      for (int i = 0; i < 500; i++) begin
         issue({$urandom, $urandom, $urandom, $urandom},
               {$urandom, $urandom, $urandom, $urandom}, i[0], TW'(i));
      end
      idle(6);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule